// File: doc/BRIEF.md
# Banked Register File for an 8-bit Controller

This block is the data memory of a small 8-bit controller core. Its storage is seen through 128-byte banks. A 7-bit offset arrives on the direct address port, and two bank bits held in the status register extend it. The low offsets of every bank are reserved for control registers. General purpose static RAM sits above them. A few heavily used control registers (program counter low byte, status, pointer, program counter high latch, interrupt control) decode at the same offset whatever the bank. Each of them is one physical register.

Offset 00h holds no storage. It is a window through the pointer register: an access there reaches the byte that the 8-bit pointer names, with pointer bit 7 choosing the bank. Any location with no storage behind it reads as zero and ignores writes. Peripheral registers are not part of this block, so their slots read as zero. Writes land on the rising clock edge. Reads are combinational.

The block has no sequencing of its own. Every access completes in the cycle it is presented, so the design is purely a decoder plus storage, and there are no states or transitions to list.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) clears the status register and the pointer register to 00h. The program counter low byte, the program counter high latch and interrupt control are also cleared to 00h.
- R2: For a direct access, bits 6:5 of the status register select the bank. A value of 00 selects bank 0 and 01 selects bank 1. The addressed location is {bank, offset[6:0]}.
- R3: General purpose RAM covers offsets 20h–7Fh of bank 0 (96 bytes) and offsets 20h–3Fh of bank 1 (32 bytes). The two ranges are separate storage, and a write to one never changes the other.
- R4: Offsets 02h (program counter low), 03h (status), 04h (pointer), 0Ah (program counter high latch) and 0Bh (interrupt control) each map to a single 8-bit register under every bank setting. A value written under one bank reads back unchanged under the other. status_out and fsr_out always show the status and pointer registers.
- R5: Locations with no storage read 00h and ignore writes. These are offsets 01h, 05h–09h and 0Ch–1Fh in banks 0 and 1, and offsets 40h–7Fh in bank 1.
- R6: When status bits 6:5 are 10 or 11, direct reads of any offset other than 00h and the R4 offsets return 00h, and writes to them are discarded. The R4 offsets stay readable and writable.
- R7: An access to offset 00h is redirected to the bank-qualified location {1'b0, fsr[7], fsr[6:0]}. Pointer bit 7 selects bank 1, and the status bank bits are not used.
- R8: An indirect access whose pointer bits 6:0 are 00h reads 00h, and a write through it changes nothing.
- R9: rdata shows the addressed byte in the same cycle that rd_en is high, and it shows 00h when rd_en is low. A write is visible from the cycle after its clock edge. A read of the same location during the write cycle returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 7 | Direct offset within the active bank |
| rd_en | input | 1 | Read strobe; enables rdata |
| wr_en | input | 1 | Write strobe; stores wdata at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data |
| status_out | output | 8 | Current status register |
| fsr_out | output | 8 | Current pointer register |

## Verification
The hardest situations to reach are those in which an access changes the very registers that steer addressing. These include a write through the indirect window when the pointer names the status or pointer register, and any access under bank settings 10 and 11. The stimulus reaches banks 2 and 3 only by writing status bits 6:5 with the values 10 and 11. It then aims the pointer at 83h and at 04h, so that indirect writes rewrite the status and pointer registers. A behavioural address map in the bench follows each of these changes cycle by cycle and compares rdata, status_out and fsr_out against the design on every access.

// File: rtl/brf_pkg.sv
package brf_pkg;
    localparam int OFF_W  = 7;
    localparam int DATA_W = 8;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_PCL,
        RG_STATUS,
        RG_PTR,
        RG_PCHI,
        RG_INTC,
        RG_RAM0,
        RG_RAM1
    } region_e;

    typedef struct packed {
        region_e            region;
        logic [OFF_W-1:0]   idx;
    } target_t;

    localparam logic [OFF_W-1:0] OFS_WINDOW = 7'h00;
    localparam logic [OFF_W-1:0] OFS_PCL    = 7'h02;
    localparam logic [OFF_W-1:0] OFS_STATUS = 7'h03;
    localparam logic [OFF_W-1:0] OFS_PTR    = 7'h04;
    localparam logic [OFF_W-1:0] OFS_PCHI   = 7'h0A;
    localparam logic [OFF_W-1:0] OFS_INTC   = 7'h0B;
endpackage

// File: rtl/brf_decode.sv
module brf_decode
    import brf_pkg::*;
#(
    parameter int RAM0_BASE  = 32,
    parameter int RAM0_DEPTH = 96,
    parameter int RAM1_BASE  = 32,
    parameter int RAM1_DEPTH = 32
) (
    input  logic [1:0]       bank,
    input  logic [OFF_W-1:0] off,
    output target_t          tgt
);
    localparam logic [OFF_W:0] R0_LO = (OFF_W+1)'(RAM0_BASE);
    localparam logic [OFF_W:0] R0_HI = (OFF_W+1)'(RAM0_BASE + RAM0_DEPTH);
    localparam logic [OFF_W:0] R1_LO = (OFF_W+1)'(RAM1_BASE);
    localparam logic [OFF_W:0] R1_HI = (OFF_W+1)'(RAM1_BASE + RAM1_DEPTH);

    logic [OFF_W:0] off_x;
    assign off_x = {1'b0, off};

    always_comb begin
        tgt.region = RG_NONE;
        tgt.idx    = '0;
        case (off)
            OFS_PCL:    tgt.region = RG_PCL;
            OFS_STATUS: tgt.region = RG_STATUS;
            OFS_PTR:    tgt.region = RG_PTR;
            OFS_PCHI:   tgt.region = RG_PCHI;
            OFS_INTC:   tgt.region = RG_INTC;
            default: begin
                if (bank == 2'b00 && off_x >= R0_LO && off_x < R0_HI) begin
                    tgt.region = RG_RAM0;
                    tgt.idx    = off - R0_LO[OFF_W-1:0];
                end else if (bank == 2'b01 && off_x >= R1_LO && off_x < R1_HI) begin
                    tgt.region = RG_RAM1;
                    tgt.idx    = off - R1_LO[OFF_W-1:0];
                end
            end
        endcase
    end
endmodule

// File: rtl/brf_core_regs.sv
module brf_core_regs
    import brf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  region_e           sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] pcl,
    output logic [DATA_W-1:0] status,
    output logic [DATA_W-1:0] ptr,
    output logic [DATA_W-1:0] pchi,
    output logic [DATA_W-1:0] intc
);
    localparam int NREG = 5;
    localparam region_e MAP [NREG] = '{RG_PCL, RG_STATUS, RG_PTR, RG_PCHI, RG_INTC};

    logic [DATA_W-1:0] regs [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[i] <= '0;
            else if (we && sel == MAP[i])
                regs[i] <= wdata;
        end
    end

    assign pcl    = regs[0];
    assign status = regs[1];
    assign ptr    = regs[2];
    assign pchi   = regs[3];
    assign intc   = regs[4];
endmodule

// File: rtl/brf_ram.sv
module brf_ram
    import brf_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [2**AW];

    always_ff @(posedge clk) begin
        if (we)
            mem[idx] <= wdata;
    end

    assign rdata = mem[idx];
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import brf_pkg::*;
#(
    parameter int RAM0_BASE  = 32,
    parameter int RAM0_DEPTH = 96,
    parameter int RAM1_BASE  = 32,
    parameter int RAM1_DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [6:0] addr,
    input  logic       rd_en,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic [7:0] status_out,
    output logic [7:0] fsr_out
);
    localparam int AW0 = $clog2(RAM0_DEPTH);
    localparam int AW1 = $clog2(RAM1_DEPTH);

    logic [DATA_W-1:0] pcl, status, ptr, pchi, intc;
    logic [DATA_W-1:0] ram0_q, ram1_q, sel_q;
    logic              via_window;
    logic [1:0]        eff_bank;
    logic [OFF_W-1:0]  eff_off;
    target_t           tgt;

    assign via_window = (addr == OFS_WINDOW);
    assign eff_bank   = via_window ? {1'b0, ptr[7]} : status[6:5];
    assign eff_off    = via_window ? ptr[6:0]       : addr;

    brf_decode #(
        .RAM0_BASE (RAM0_BASE),
        .RAM0_DEPTH(RAM0_DEPTH),
        .RAM1_BASE (RAM1_BASE),
        .RAM1_DEPTH(RAM1_DEPTH)
    ) u_dec (
        .bank(eff_bank),
        .off (eff_off),
        .tgt (tgt)
    );

    brf_core_regs u_core (
        .clk   (clk),
        .rst   (rst),
        .we    (wr_en),
        .sel   (tgt.region),
        .wdata (wdata),
        .pcl   (pcl),
        .status(status),
        .ptr   (ptr),
        .pchi  (pchi),
        .intc  (intc)
    );

    brf_ram #(.DEPTH(RAM0_DEPTH)) u_ram0 (
        .clk  (clk),
        .we   (wr_en && tgt.region == RG_RAM0),
        .idx  (tgt.idx[AW0-1:0]),
        .wdata(wdata),
        .rdata(ram0_q)
    );

    brf_ram #(.DEPTH(RAM1_DEPTH)) u_ram1 (
        .clk  (clk),
        .we   (wr_en && tgt.region == RG_RAM1),
        .idx  (tgt.idx[AW1-1:0]),
        .wdata(wdata),
        .rdata(ram1_q)
    );

    always_comb begin
        unique case (tgt.region)
            RG_PCL:    sel_q = pcl;
            RG_STATUS: sel_q = status;
            RG_PTR:    sel_q = ptr;
            RG_PCHI:   sel_q = pchi;
            RG_INTC:   sel_q = intc;
            RG_RAM0:   sel_q = ram0_q;
            RG_RAM1:   sel_q = ram1_q;
            default:   sel_q = '0;
        endcase
    end

    assign rdata      = rd_en ? sel_q : '0;
    assign status_out = status;
    assign fsr_out    = ptr;
endmodule

// File: rtl/brf_checker.sv
module brf_checker (
    input logic       clk,
    input logic       rst,
    input logic [6:0] addr,
    input logic       rd_en,
    input logic       wr_en,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [7:0] status_out,
    input logic [7:0] fsr_out
);
    logic is_mirror;
    assign is_mirror = (addr == 7'h02) || (addr == 7'h03) || (addr == 7'h04) ||
                       (addr == 7'h0A) || (addr == 7'h0B);

    // R4: direct write to the pointer lands in any bank
    a_r4_ptr_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 7'h04) |=> (fsr_out == $past(wdata)));

    // R4: direct write to the status register lands in any bank
    a_r4_status_write: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr == 7'h03) |=> (status_out == $past(wdata)));

    // R4: pointer holds unless written directly or through the window
    a_r4_ptr_hold: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (addr == 7'h04 || (addr == 7'h00 && fsr_out[6:0] == 7'h04)))
        |=> $stable(fsr_out));

    // R5: bank 1 offsets 40h-7Fh read as zero
    a_r5_hole_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && status_out[6:5] == 2'b01 && addr >= 7'h40) |-> (rdata == 8'h00));

    // R6: banks 2 and 3 read zero outside the mirrored offsets
    a_r6_upper_bank_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && status_out[6] && addr != 7'h00 && !is_mirror) |-> (rdata == 8'h00));

    // R8: window aimed at itself reads zero
    a_r8_self_window: assert property (@(posedge clk) disable iff (rst)
        (rd_en && addr == 7'h00 && fsr_out[6:0] == 7'h00) |-> (rdata == 8'h00));

    // R9: no read strobe, no data
    a_r9_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !rd_en |-> (rdata == 8'h00));
endmodule

bind banked_regfile brf_checker u_chk (.*);

// File: tb/banked_regfile_test.sv
`timescale 1ns/1ps
module banked_regfile_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [6:0] addr = '0;
    logic       rd_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata, status_out, fsr_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    logic [7:0] mm [int];

    banked_regfile uut (
        .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .wdata(wdata), .rdata(rdata), .status_out(status_out), .fsr_out(fsr_out)
    );

    always #2.5 clk = ~clk;

    function automatic int resolve(input logic [1:0] b, input logic [6:0] o);
        if (o == 2 || o == 3 || o == 4 || o == 10 || o == 11) return int'(o);
        if (b == 2'd0 && o >= 7'h20) return int'(o);
        if (b == 2'd1 && o >= 7'h20 && o < 7'h40) return 128 + int'(o);
        return -1;
    endfunction

    function automatic int key_of(input logic [6:0] a);
        logic [7:0] p;
        p = mm[4];
        if (a == 0) begin
            if (p[6:0] == 0) return -1;
            return resolve({1'b0, p[7]}, p[6:0]);
        end
        return resolve(mm[3][6:5], a);
    endfunction

    function automatic logic [7:0] model_read(input logic [6:0] a);
        int k;
        k = key_of(a);
        if (k < 0) return 8'h00;
        if (mm.exists(k)) return mm[k];
        return 8'hxx;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic [6:0] a, input logic rd, input logic wr,
                       input logic [7:0] d, input string req);
        int k;
        @(negedge clk);
        addr = a; rd_en = rd; wr_en = wr; wdata = d;
        #1;
        chk(req, rdata, rd ? model_read(a) : 8'h00);
        chk({req, " status"}, status_out, mm[3]);
        chk({req, " pointer"}, fsr_out, mm[4]);
        k = key_of(a);
        @(posedge clk);
        if (wr && k >= 0) mm[k] = d;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; rd_en = 0; wr_en = 0;
        @(posedge clk);
        mm[2] = 0; mm[3] = 0; mm[4] = 0; mm[10] = 0; mm[11] = 0;
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 status", status_out, 8'h00);
        chk("R1 pointer", fsr_out, 8'h00);
    endtask

    initial begin
        do_reset();
        cyc(7'h02, 1, 0, 0, "R1 pcl");
        cyc(7'h0B, 1, 0, 0, "R1 intc");

        // R3 / R2: fill bank 0 and bank 1 RAM with distinct patterns
        for (int i = 32; i < 128; i++) cyc(7'(i), 0, 1, 8'(i) ^ 8'h5A, "R3 fill0");
        cyc(7'h03, 0, 1, 8'h20, "R2 select bank1");
        for (int i = 32; i < 64; i++) cyc(7'(i), 0, 1, 8'(i) + 8'h11, "R3 fill1");
        for (int i = 32; i < 64; i++) cyc(7'(i), 1, 0, 0, "R3 read1");
        cyc(7'h03, 0, 1, 8'h00, "R2 select bank0");
        for (int i = 32; i < 128; i++) cyc(7'(i), 1, 0, 0, "R3 read0");

        // R4: mirrors across banks
        cyc(7'h0A, 0, 1, 8'h3C, "R4 pchi");
        cyc(7'h0B, 0, 1, 8'hC3, "R4 intc");
        cyc(7'h02, 0, 1, 8'h77, "R4 pcl");
        cyc(7'h03, 0, 1, 8'h20, "R4 to bank1");
        cyc(7'h0A, 1, 0, 0, "R4 pchi bank1");
        cyc(7'h0B, 1, 0, 0, "R4 intc bank1");
        cyc(7'h02, 1, 1, 8'h99, "R9 old value in write cycle");
        cyc(7'h02, 1, 0, 0, "R9 new value next cycle");

        // R5: holes in bank 1 and control slots
        for (int i = 64; i < 128; i++) cyc(7'(i), 0, 1, 8'hEE, "R5 write hole");
        for (int i = 64; i < 128; i += 7) cyc(7'(i), 1, 0, 0, "R5 read hole");
        for (int i = 1; i < 32; i++) cyc(7'(i), 1, 1, 8'hA5, "R5 slot");
        cyc(7'h03, 0, 1, 8'h00, "R5 to bank0");
        for (int i = 1; i < 32; i++) cyc(7'(i), 1, (i > 4) ? 1'b1 : 1'b0, 8'h5B, "R5 slot0");
        for (int i = 64; i < 128; i += 5) cyc(7'(i), 1, 0, 0, "R5 bank0 intact");

        // R6: banks 2 and 3
        cyc(7'h03, 0, 1, 8'h40, "R6 bank2");
        cyc(7'h20, 1, 1, 8'h12, "R6 bank2 write ram");
        cyc(7'h20, 1, 0, 0, "R6 bank2 read ram");
        cyc(7'h0B, 0, 1, 8'h81, "R6 mirror write");
        cyc(7'h0B, 1, 0, 0, "R6 mirror read");
        cyc(7'h03, 0, 1, 8'h60, "R6 bank3");
        cyc(7'h30, 1, 1, 8'h34, "R6 bank3 write");
        cyc(7'h04, 1, 1, 8'hA5, "R6 bank3 pointer");
        cyc(7'h04, 1, 0, 0, "R6 bank3 pointer read");
        cyc(7'h03, 0, 1, 8'h00, "R6 back to bank0");
        cyc(7'h20, 1, 0, 0, "R6 bank0 ram intact");
        cyc(7'h30, 1, 0, 0, "R6 bank0 ram intact");

        // R7: indirect window
        cyc(7'h04, 0, 1, 8'h25, "R7 ptr bank0");
        cyc(7'h00, 1, 1, 8'hAB, "R7 window write");
        cyc(7'h25, 1, 0, 0, "R7 direct view");
        cyc(7'h04, 0, 1, 8'hA5, "R7 ptr bank1");
        cyc(7'h00, 1, 1, 8'hCD, "R7 window bank1");
        cyc(7'h25, 1, 0, 0, "R7 bank0 untouched");
        cyc(7'h03, 0, 1, 8'h20, "R7 to bank1");
        cyc(7'h25, 1, 0, 0, "R7 bank1 view");
        cyc(7'h04, 0, 1, 8'h83, "R7 ptr status");
        cyc(7'h00, 1, 1, 8'h00, "R7 status via window");
        cyc(7'h25, 1, 0, 0, "R7 bank0 after status");
        cyc(7'h04, 0, 1, 8'h04, "R7 ptr self");
        cyc(7'h00, 1, 1, 8'h80, "R7 pointer via window");
        cyc(7'h00, 1, 0, 0, "R7 reach bank1 offset0");

        // R8: window aimed at offset 00h
        cyc(7'h04, 0, 1, 8'h00, "R8 ptr 00");
        cyc(7'h00, 1, 1, 8'h55, "R8 window self");
        cyc(7'h00, 1, 0, 0, "R8 window self read");
        cyc(7'h04, 0, 1, 8'h80, "R8 ptr 80");
        cyc(7'h00, 1, 1, 8'h66, "R8 window self bank1");
        cyc(7'h04, 1, 0, 0, "R8 pointer unchanged");

        // R9: no strobe, no data
        cyc(7'h25, 0, 0, 0, "R9 idle");
        cyc(7'h04, 0, 0, 0, "R9 idle");

        // R1: reset from a busy state
        cyc(7'h03, 0, 1, 8'h3F, "R1 dirty status");
        do_reset();
        cyc(7'h0A, 1, 0, 0, "R1 pchi cleared");

        @(negedge clk);
        rd_en = 0; wr_en = 0;
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end
endmodule